// File: doc/BRIEF.md
# Serial Slave Pause (Hold) Controller

This block handles the pause input of a serial memory slave port. It watches chip select (active low), the serial clock and the pause pin (active low), all of them already synchronized to the system clock. It produces a `hold_active` flag that freezes the slave's bit-level logic. It also drives an output enable for the serial data output and a one-cycle `logic_rst` pulse. The pulse fires when the master deselects the device while a pause is in force. The command decoder is not part of this block. A shift register and bit counter stand in for it. They advance on serial clock rising edges and must not move during a pause.

A pause starts or ends only while the serial clock is low. A request that arrives while the clock is high waits until the clock next drops. If the device is deselected during a pause, the interface is reset and then locked out. It stays locked until a cycle in which both pins are high, with the pause released first and the device still deselected. Only after that can a new select restart traffic. This order keeps the device from dropping straight back into a pause.

Top module: `spi_hold_ctrl`

## Requirements
- R1: `hold_active` rises on the clock after one sampled cycle in which `hold_n`=0, `sck`=0, `cs_n`=0 and no lockout holds. While `sck` stays high, a low `hold_n` does not start a pause.
- R2: Once paused, `hold_active` falls on the clock after a sampled cycle with `hold_n`=1 and `sck`=0. While `sck` stays high, a high `hold_n` does not end the pause.
- R3: `so_oe` is 1 exactly when the device is selected (`cs_n`=0, registered) and neither a pause nor a lockout is in force. It is 0 during a pause.
- R4: While paused with `cs_n` low, `shift_cnt` and `shift_data` keep their values, whatever `sck` and `si` do.
- R5: Sampling `cs_n`=1 during a pause gives `logic_rst`=1 for exactly one cycle. On that same clock `hold_active` and `shift_cnt` clear. A deselect outside a pause gives no pulse.
- R6: After R5's reset the block is locked out. While locked it does not pause, does not shift, and holds `so_oe` at 0, even if `cs_n` goes low again. The lockout ends after a sampled cycle with both `cs_n`=1 and `hold_n`=1. `hold_n` rising while `cs_n` is low does not end it.
- R7: `hold_n` has no effect while `cs_n` is high. `hold_active` stays 0.
- R8: A rising `sck` seen with `cs_n` low, no pause and no lockout shifts `si` into bit 0 of `shift_data`, moving the older bits up. It also increments `shift_cnt` modulo 2^CNT_W. A sampled `cs_n`=1 clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low, synchronized |
| sck | input | 1 | Serial clock level, synchronized |
| hold_n | input | 1 | Pause request, active low, synchronized |
| si | input | 1 | Serial data in |
| hold_active | output | 1 | Pause in force |
| so_oe | output | 1 | Output enable for the serial data output |
| logic_rst | output | 1 | One-cycle interface reset pulse |
| shift_cnt | output | CNT_W | Received bit counter |
| shift_data | output | DATA_W | Received bit shift register |

## Verification
The checker watches on every cycle that a pause starts only after a sampled low clock with the pin low, and ends only after a sampled low clock with the pin high. It also checks that the output enable is off during a pause, that the counter does not move during a pause or a lockout, that a deselect during a pause yields the reset pulse, and that a deselected device never reports a pause. Some behaviour shows only in the bench's scenarios. These are the deferred entry and exit when the pin changes with the clock high, and the wrong-order release that must keep the lockout. The bench also covers the full exit sequence and wrap of the counter across more than its whole range.

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl #(
  parameter int CNT_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              hold_n,
  input  logic              si,
  output logic              hold_active,
  output logic              so_oe,
  output logic              logic_rst,
  output logic [CNT_W-1:0]  shift_cnt,
  output logic [DATA_W-1:0] shift_data
);

  logic sck_q, hold_q, locked_q, sel_q, rst_q;
  logic sck_rise, shift_en, drop_in_hold;

  assign sck_rise     = sck & ~sck_q;
  assign drop_in_hold = cs_n & hold_q;
  assign shift_en     = ~cs_n & ~hold_q & ~locked_q & sck_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= 1'b0;
      hold_q   <= 1'b0;
      locked_q <= 1'b0;
      sel_q    <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      sck_q <= sck;
      sel_q <= ~cs_n;
      rst_q <= drop_in_hold;
      if (drop_in_hold)
        locked_q <= 1'b1;
      else if (cs_n && hold_n)
        locked_q <= 1'b0;
      if (cs_n || locked_q)
        hold_q <= 1'b0;
      else if (!sck)
        hold_q <= ~hold_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_cnt  <= '0;
      shift_data <= '0;
    end else if (cs_n) begin
      shift_cnt  <= '0;
      shift_data <= '0;
    end else if (shift_en) begin
      shift_cnt  <= shift_cnt + 1'b1;
      shift_data <= {shift_data[DATA_W-2:0], si};
    end
  end

  assign hold_active = hold_q;
  assign logic_rst   = rst_q;
  assign so_oe       = sel_q & ~hold_q & ~locked_q;

endmodule

// File: rtl/spi_hold_ctrl_chk.sv
module spi_hold_ctrl_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             sck,
  input logic             hold_n,
  input logic             hold_active,
  input logic             so_oe,
  input logic             logic_rst,
  input logic             locked_q,
  input logic [CNT_W-1:0] shift_cnt
);

  a_r1_entry_on_low_sck: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_active) |-> $past(!sck && !hold_n && !cs_n));

  a_r2_exit_on_low_sck: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hold_active) && $past(!cs_n && !locked_q)) |-> $past(!sck && hold_n));

  a_r3_so_off_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |-> !so_oe);

  a_r4_frozen_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hold_active && !cs_n) |-> $stable(shift_cnt));

  a_r5_reset_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hold_active && cs_n) |-> (logic_rst && !hold_active && shift_cnt == '0));

  a_r6_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(locked_q && !cs_n) |-> ($stable(shift_cnt) && !hold_active));

  a_r7_no_hold_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> !hold_active);

endmodule

bind spi_hold_ctrl spi_hold_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
  .hold_active(hold_active), .so_oe(so_oe), .logic_rst(logic_rst),
  .locked_q(locked_q), .shift_cnt(shift_cnt)
);

// File: tb/sim_spi_hold_ctrl.sv
`timescale 1ns/1ps
module sim_spi_hold_ctrl;
  localparam int CNT_W  = 4;
  localparam int DATA_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, hold_n = 1'b1, si = 1'b0;
  logic hold_active, so_oe, logic_rst;
  logic [CNT_W-1:0]  shift_cnt;
  logic [DATA_W-1:0] shift_data;

  int checks = 0, errors = 0;
  int exp_cnt = 0;
  logic [DATA_W-1:0] exp_data = '0;
  bit done = 0;

  always #4 clk = ~clk;

  spi_hold_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
    .si(si), .hold_active(hold_active), .so_oe(so_oe), .logic_rst(logic_rst),
    .shift_cnt(shift_cnt), .shift_data(shift_data)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    si = b; sck = 1'b1; step();
    exp_cnt  = (exp_cnt + 1) % (1 << CNT_W);
    exp_data = {exp_data[DATA_W-2:0], b};
    sck = 1'b0; step();
  endtask

  task automatic pulse_ignored(input logic b);
    si = b; sck = 1'b1; step();
    sck = 1'b0; step();
  endtask

  task automatic check_shift(input string req);
    check({req, " cnt"}, int'(shift_cnt), exp_cnt);
    check({req, " data"}, int'(shift_data), int'(exp_data));
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1'b1; step();
    check("reset hold_active", int'(hold_active), 0);
    check("reset so_oe R3", int'(so_oe), 0);
    check("reset logic_rst", int'(logic_rst), 0);
    check_shift("reset R8");

    // R7: pin low while deselected
    hold_n = 1'b0; step(); step();
    check("R7 deselected hold ignored", int'(hold_active), 0);
    hold_n = 1'b1; step();

    cs_n = 1'b0; step();
    check("R3 selected so_oe", int'(so_oe), 1);
    send_bit(1); send_bit(0); send_bit(1);
    check_shift("R8 three bits");

    // R1 immediate entry with sck low
    hold_n = 1'b0; step();
    check("R1 immediate entry", int'(hold_active), 1);
    check("R3 so_oe off in hold", int'(so_oe), 0);
    for (int i = 0; i < 4; i++) pulse_ignored(i[0]);
    check_shift("R4 frozen in hold");
    check("R4 still held", int'(hold_active), 1);

    // R2 deferred exit
    sck = 1'b1; step();
    hold_n = 1'b1; step();
    check("R2 no exit while sck high", int'(hold_active), 1);
    check_shift("R4 rise during hold ignored");
    sck = 1'b0; step();
    check("R2 exit at sck low", int'(hold_active), 0);
    check("R3 so_oe back on", int'(so_oe), 1);

    // R1 deferred entry
    si = 1'b1; sck = 1'b1; step();
    exp_cnt = (exp_cnt + 1) % (1 << CNT_W);
    exp_data = {exp_data[DATA_W-2:0], 1'b1};
    hold_n = 1'b0; step();
    check("R1 no entry while sck high", int'(hold_active), 0);
    sck = 1'b0; step();
    check("R1 entry at sck low", int'(hold_active), 1);
    check_shift("R4 after deferred entry");
    hold_n = 1'b1; step();
    check("R2 immediate exit", int'(hold_active), 0);

    // R8 sweep across counter wrap
    for (int n = 0; n < 20; n++) begin
      send_bit(logic'((n * 5 + 3) % 7 > 3));
      check("R8 sweep cnt", int'(shift_cnt), exp_cnt);
    end
    check("R8 sweep data", int'(shift_data), int'(exp_data));

    // R5 plain deselect: no pulse
    cs_n = 1'b1; step();
    exp_cnt = 0; exp_data = '0;
    check("R5 plain deselect no pulse", int'(logic_rst), 0);
    check_shift("R8 deselect clears");
    cs_n = 1'b0; step();
    send_bit(1); send_bit(1);

    // R5 deselect during hold
    hold_n = 1'b0; step();
    check("R1 entry before reset", int'(hold_active), 1);
    cs_n = 1'b1; step();
    exp_cnt = 0; exp_data = '0;
    check("R5 pulse", int'(logic_rst), 1);
    check("R5 hold cleared", int'(hold_active), 0);
    check_shift("R5 cleared");
    cs_n = 1'b0; step();
    check("R5 pulse one cycle", int'(logic_rst), 0);

    // R6 lockout
    check("R6 no hold while locked", int'(hold_active), 0);
    check("R6 so_oe off while locked", int'(so_oe), 0);
    pulse_ignored(1); pulse_ignored(0);
    check_shift("R6 no shift while locked");
    hold_n = 1'b1; step(); step();
    check("R6 wrong order stays locked", int'(so_oe), 0);
    pulse_ignored(1);
    check_shift("R6 wrong order no shift");
    cs_n = 1'b1; step();
    cs_n = 1'b0; step();
    check("R6 resumed so_oe", int'(so_oe), 1);
    send_bit(1);
    check_shift("R6 resumed shift");
    hold_n = 1'b0; step();
    check("R6 hold works again", int'(hold_active), 1);
    hold_n = 1'b1; step();
    check("R2 release after resume", int'(hold_active), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule